// File: doc/BRIEF.md
# Multi-Channel Timer Unit Register Decoder

This block is the top level of a small timer unit. It holds two or three down-counting timer channels behind one register space. Most of the block is address decoding. A word at offset 0x04 acts as a shared start register, and each of its low bits enables one channel. An optional one-bit output-control word sits at offset 0x00. The channel register windows sit at the irregular bases 0x08, 0x14 and 0x20. A channel receives write strobes only for accesses that fall in its own window, together with the offset relative to the window base. Each channel drives its own interrupt line.

Accesses use a single-cycle strobe. Read data is combinational and valid while `rd_en` is high. An access to an undecoded or disabled offset returns zero on read and is dropped on write. Such an access raises `err` for exactly one cycle, in the cycle after the strobe. The channel count (2 or 3) and the presence of the output-control word are parameters.

Top module: `tmr_unit`

## Requirements
- R1: After reset the start word and the output-control bit are 0 and `err` and all `irq` bits are low. Every channel's reload and count words read 0xFFFFFFFF, and its control word reads 0.
- R2: Bit n of the start word (offset 0x04) runs channel n when 1 and stops it when 0. A read returns the bits last written for bits 0..NCH-1, and the bits above them read 0.
- R3: When HAS_OCTL=1, offset 0x00 stores bit 0 of a write, reads back as bit 0 and drives `out_ctl`. When HAS_OCTL=0, offset 0x00 is undecoded.
- R4: Channel 0 decodes 0x08–0x13, channel 1 decodes 0x14–0x1F and channel 2 decodes 0x20–0x2F. Inside a window the relative offset selects reload at 0x0, count at 0x4 and control at 0x8. Relative offset 0xC is a capture word that exists on channel 2 only.
- R5: A running channel decrements its count by one per clock. When a running channel's count is 0, the next clock loads the reload value and sets the underflow flag. A write to the count word takes priority over counting.
- R6: In the control word, bit 5 is the interrupt enable and bit 8 is the underflow flag. Writing 0 to bit 8 clears the flag, and writing 1 to bit 8 has no effect. `irq[n]` is high when channel n has both its flag and its enable set.
- R7: A stopped channel holds its count.
- R8: With NCH=2, offsets 0x20–0x2F are undecoded. A start-word write with bit 2 set is an error and leaves the start word unchanged.
- R9: An access to an undecoded offset reads 0 and changes no state. Such an access raises `err` for one cycle, in the cycle after the strobe. Offsets 0x30 and above are always undecoded.
- R10: Read data reflects the addressed register in the same cycle as `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | AW | Byte offset into the unit |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| err | output | 1 | One-cycle pulse after a bad access |
| out_ctl | output | 1 | Stored output-control bit |
| irq | output | NCH | Per-channel interrupt |

## Verification
A wrong start bit does not wait for a read to become visible. Within a clock the affected channel's count diverges from the model, and its `irq` line departs a few cycles later. A decode error on one window boundary shows up in two places. The next read of the neighbouring register returns the wrong word. The `err` pulse also appears in the cycle after the strobe when it should not, or stays absent when it should appear. Both are observed on every clock against a behavioural model.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW   = 32,
  parameter int CAPT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr,
  input  logic [3:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [DW-1:0] rl, cnt, cap;
  logic          ie, flag;

  wire wr_rl = wr && off[3:2] == 2'd0;
  wire wr_cn = wr && off[3:2] == 2'd1;
  wire wr_ct = wr && off[3:2] == 2'd2;
  wire wr_cp = wr && off[3:2] == 2'd3 && CAPT != 0;
  wire uf    = run && !wr_cn && cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl   <= '1;
      cnt  <= '1;
      cap  <= '0;
      ie   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_rl) rl <= wdata;
      if (wr_cn) cnt <= wdata;
      else if (run) cnt <= uf ? rl : cnt - 1'b1;
      if (wr_ct) ie <= wdata[5];
      if (uf) flag <= 1'b1;
      else if (wr_ct && !wdata[8]) flag <= 1'b0;
      if (wr_cp) cap <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (off[3:2])
      2'd0: rdata = rl;
      2'd1: rdata = cnt;
      2'd2: begin rdata[8] = flag; rdata[5] = ie; end
      default: rdata = (CAPT != 0) ? cap : '0;
    endcase
  end

  assign irq = flag && ie;

  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cn) |=> $stable(cnt));
  assert_flag_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(run));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int NCH      = 3,
  parameter int HAS_OCTL = 1,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           err,
  output logic           out_ctl,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0] start_q;
  logic           octl_q;
  logic           err_q;
  logic [NCH-1:0] hit;
  logic [DW-1:0]  ch_rd [NCH];

  wire sel_oc = (HAS_OCTL != 0) && addr < AW'(4);
  wire sel_st = addr >= AW'(4) && addr < AW'(8);
  wire st_err = sel_st && wr_en && (NCH < 3) && wdata[2];
  wire bad    = !(sel_oc || sel_st || (|hit)) || st_err;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int BASE = (i == 0) ? 8 : ((i == 1) ? 20 : 32);
    localparam int NW   = (i == 2) ? 4 : 3;
    logic [AW-1:0] rel;
    assign hit[i] = addr >= AW'(BASE) && addr < AW'(BASE + 4 * NW);
    assign rel    = addr - AW'(BASE);
    tmr_chan #(.DW(DW), .CAPT(i == 2 ? 1 : 0)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (start_q[i]),
      .wr    (wr_en && hit[i]),
      .off   (rel[3:0]),
      .wdata (wdata),
      .rdata (ch_rd[i]),
      .irq   (irq[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      octl_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (wr_en || rd_en) && bad;
      if (wr_en && sel_oc) octl_q <= wdata[0];
      if (wr_en && sel_st && !st_err) start_q <= wdata[NCH-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_oc) rdata[0] = octl_q;
    else if (sel_st) rdata[NCH-1:0] = start_q;
    for (int i = 0; i < NCH; i++)
      if (hit[i]) rdata = ch_rd[i];
  end

  assign err     = err_q;
  assign out_ctl = octl_q;

  assert_err_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en || rd_en));
  assert_bad_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bad) |=> $stable(start_q) && $stable(octl_q));
  assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && bad) |-> rdata == '0);
  assert_start_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_st && !st_err) |=> !err);
endmodule

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
  logic clk = 0, rst_n = 0;
  logic wr = 0, rd = 0;
  logic [7:0] addr = 0;
  logic [31:0] wd = 0, rdata;
  logic err, out_ctl;
  logic [2:0] irq;
  logic wr2 = 0, rd2 = 0;
  logic [7:0] addr2 = 0;
  logic [31:0] wd2 = 0, rdata2;
  logic err2, out_ctl2;
  logic [1:0] irq2;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_unit #(.NCH(3), .HAS_OCTL(1)) i_tmr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .rd_en(rd), .addr(addr), .wdata(wd),
    .rdata(rdata), .err(err), .out_ctl(out_ctl), .irq(irq));
  tmr_unit #(.NCH(2), .HAS_OCTL(0)) i_tmr_unit_two (
    .clk(clk), .rst_n(rst_n), .wr_en(wr2), .rd_en(rd2), .addr(addr2), .wdata(wd2),
    .rdata(rdata2), .err(err2), .out_ctl(out_ctl2), .irq(irq2));

  bit [31:0] m_rl[3], m_cn[3];
  bit [31:0] m_cap;
  bit m_ie[3], m_fl[3];
  bit [2:0] m_start;
  bit m_octl, m_err;

  // kind: 0 octl, 1 start, 2 channel, 3 bad
  function automatic void dec(input int a, output int kind, output int ch, output int rg);
    ch = 0; rg = 0;
    if (a < 4) kind = 0;
    else if (a < 8) kind = 1;
    else if (a < 20) begin kind = 2; ch = 0; rg = (a - 8) / 4; end
    else if (a < 32) begin kind = 2; ch = 1; rg = (a - 20) / 4; end
    else if (a < 48) begin kind = 2; ch = 2; rg = (a - 32) / 4; end
    else kind = 3;
  endfunction

  function automatic bit [31:0] mread(input int a);
    int k, c, r;
    dec(a, k, c, r);
    case (k)
      0: return {31'd0, m_octl};
      1: return {29'd0, m_start};
      2: case (r)
           0: return m_rl[c];
           1: return m_cn[c];
           2: return (32'(m_fl[c]) << 8) | (32'(m_ie[c]) << 5);
           default: return m_cap;
         endcase
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_rl[i] = '1; m_cn[i] = '1; m_ie[i] = 0; m_fl[i] = 0; end
      m_cap = 0; m_start = 0; m_octl = 0; m_err = 0;
    end else begin
      int k, c, r;
      bit [2:0] st_old;
      dec(addr, k, c, r);
      st_old = m_start;
      for (int i = 0; i < 3; i++) begin
        bit wcn, wct, wrl, uf;
        wrl = wr && k == 2 && c == i && r == 0;
        wcn = wr && k == 2 && c == i && r == 1;
        wct = wr && k == 2 && c == i && r == 2;
        uf  = st_old[i] && !wcn && m_cn[i] == 0;
        if (wcn) m_cn[i] = wd;
        else if (st_old[i]) m_cn[i] = uf ? m_rl[i] : m_cn[i] - 1;
        if (uf) m_fl[i] = 1;
        else if (wct && !wd[8]) m_fl[i] = 0;
        if (wct) m_ie[i] = wd[5];
        if (wrl) m_rl[i] = wd;
      end
      if (wr && k == 2 && c == 2 && r == 3) m_cap = wd;
      if (wr && k == 0) m_octl = wd[0];
      if (wr && k == 1) m_start = wd[2:0];
      m_err = (wr || rd) && k == 3;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit [2:0] ei;
    for (int i = 0; i < 3; i++) ei[i] = m_fl[i] & m_ie[i];
    check(irq == ei, "R6 irq", irq, ei);
    check(err == m_err, "R9 err", err, m_err);
    check(out_ctl == m_octl, "R3 out_ctl", out_ctl, m_octl);
  end

  task automatic acc(input bit w, input bit r, input int a, input bit [31:0] d, input string req);
    @(negedge clk);
    wr = w; rd = r; addr = 8'(a); wd = d;
    #1;
    if (r) check(rdata == mread(a), req, rdata, mread(a));
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); wr = 0; rd = 0; end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 48; a += 4) acc(0, 1, a, 0, req);
    idle(1);
  endtask

  task automatic acc2(input bit w, input bit r, input int a, input bit [31:0] d,
                      input bit exp_err, input bit [31:0] exp_rd, input string req);
    @(negedge clk);
    wr2 = w; rd2 = r; addr2 = 8'(a); wd2 = d;
    #1;
    if (r) check(rdata2 == exp_rd, req, rdata2, exp_rd);
    @(negedge clk);
    wr2 = 0; rd2 = 0;
    check(err2 == exp_err, req, err2, exp_err);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(err == 0 && irq == 0 && out_ctl == 0, "R1 reset outputs", {err, irq, out_ctl}, 0);
    sweep("R1 reset readback");
    acc(1, 0, 8'h08, 5, "R4");  acc(1, 0, 8'h14, 3, "R4");  acc(1, 0, 8'h20, 7, "R4");
    acc(1, 0, 8'h0C, 2, "R4");  acc(1, 0, 8'h18, 2, "R4");  acc(1, 0, 8'h24, 2, "R4");
    acc(1, 0, 8'h10, 32'h20, "R6"); acc(1, 0, 8'h1C, 32'h20, "R6"); acc(1, 0, 8'h28, 32'h20, "R6");
    acc(1, 0, 8'h2C, 32'hCAFE0001, "R4 capture");
    sweep("R4 windows");
    acc(1, 0, 8'h04, 32'hFFFF_FFF7, "R2 start");
    acc(0, 1, 8'h04, 0, "R2 start readback");
    idle(12);
    sweep("R5 counting");
    acc(1, 0, 8'h1C, 32'h20, "R6 clear flag");
    acc(1, 0, 8'h10, 32'h120, "R6 write one keeps flag");
    acc(1, 0, 8'h04, 32'h5, "R7 stop ch1");
    idle(9);
    sweep("R7 stopped hold");
    acc(1, 0, 8'h0C, 0, "R5 count write");
    idle(3);
    acc(1, 0, 8'h00, 32'hFFFF_FFFF, "R3 octl");
    acc(0, 1, 8'h00, 0, "R3 octl readback");
    acc(1, 0, 8'h00, 32'h2, "R3 octl bit0 only");
    acc(1, 0, 8'h30, 32'hFFFF_FFFF, "R9 bad write");
    acc(0, 1, 8'h44, 0, "R9 bad read zero R10");
    acc(1, 0, 8'hFC, 32'h1, "R9 bad write");
    idle(2);
    sweep("R9 state unchanged");
    acc(1, 1, 8'h04, 0, "R10 write and read");
    idle(20);
    sweep("R10 final");
    acc2(1, 0, 8'h00, 1, 1, 0, "R3 no octl err");
    acc2(0, 1, 8'h00, 0, 1, 0, "R3 no octl read");
    acc2(1, 0, 8'h04, 32'h4, 1, 0, "R8 start bit2 err");
    acc2(0, 1, 8'h04, 0, 0, 0, "R8 start unchanged");
    acc2(1, 0, 8'h04, 32'h3, 0, 0, "R8 legal start");
    acc2(0, 1, 8'h04, 0, 0, 3, "R2 two-ch readback");
    acc2(0, 1, 8'h20, 0, 1, 0, "R8 ch2 window absent");
    acc2(0, 1, 8'h14, 0, 0, 32'hFFFF_FFFF, "R4 two-ch ch1 reload");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule